// File: doc/BRIEF.md
# Descriptor-Driven Memory Transfer Engine

This block moves data between two memory locations using per-channel control records that live in ordinary data memory rather than in internal registers. An activation request carries a channel vector. The engine locates that channel's four-word record at `DESC_BASE + vector*16` and reads it over a single-master memory port. It performs the transfer that the record describes and then stores the updated record back in the same place. Because each channel costs only sixteen bytes of memory, the channel count is limited by the space set aside for records.

Each record selects one of three modes:
- **Normal:** one unit per request, with a 16-bit count.
- **Repeat:** one unit per request. One side cycles through a small area, and its address and an 8-bit counter reload when the counter runs out.
- **Block:** a group of units per request. One side is a block area that rewinds after each group.

A record can also ask the engine to continue, within the same activation, with the record that follows it in memory. This can be unconditional, or only when its counter has just reached zero.

Top module: `dtc_engine`

## Requirements
- R1: When idle, a one-cycle `act_req` starts an activation for `act_vec`. `busy` is high from the next cycle until the activation ends. `done` is a single-cycle pulse at the end, and `act_req` while `busy` is high is ignored.
- R2: The record is read as four longword accesses at `DESC_BASE + vec*16 + {0,4,8,12}`. It is written back to the same four addresses, and the control word (word 0) is written back unchanged.
- R3: Control word bits [3:2] select the unit size: 0 is byte, 1 is word, 2 is longword. Read data is zero-extended, and only the low 1, 2 or 4 bytes of the destination are written.
- R4: Control bits [5:4] (source) and [7:6] (destination) independently select how the address moves after each unit: 0 keeps it fixed, 1 increments it by the unit size, and 2 decrements it by the unit size. Word 1 holds the source address and word 2 the destination address.
- R5: Control bits [1:0] select the mode: 0 is normal, 1 is repeat, 2 is block. In normal mode one unit moves per activation and the 16-bit count in word 3 bits [31:16] decreases by one. A count of 0 stands for 65536 and becomes 0xFFFF.
- R6: In repeat mode one unit moves per activation and the 8-bit counter in word 3 bits [7:0] decreases by one. When that counter goes from 1 to the end, it reloads from word 3 bits [15:8] (0 stands for 256), and the area-side address returns to where the area starts. A counter of 0 steps to 255 without reloading.
- R7: In block mode each activation moves the number of units given by word 3 bits [15:8] (0 stands for 256). The block-area address rewinds to its start after the group, the other address keeps advancing, and the 16-bit count decreases once per group.
- R8: Control bit 8 names the area side for repeat and block modes: 0 is the source, 1 is the destination. The other side never rewinds.
- R9: With control bit 9 set, after write-back the engine processes the record 16 bytes further on within the same activation. Only one `done` is raised for the whole chain.
- R10: With bits 9 and 10 both set, chaining happens only when the record's counter has just reached zero. That counter is the 16-bit count in normal and block modes, and the 8-bit counter in repeat mode.
- R11: The memory port returns read data one cycle after a read request, and it issues no request while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_req | input | 1 | Activation request |
| act_vec | input | VEC_W | Channel vector of the request |
| busy | output | 1 | Activation in progress |
| done | output | 1 | One-cycle end-of-activation pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_size | output | 2 | Access size: 0 byte, 1 word, 2 longword |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data, low bytes significant |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The bench sweeps every combination of unit size and source/destination address control in normal mode. A wrong step or sign would leave a misplaced address in the written-back record, and a missing size mask would spill extra bytes into the destination.

Repeat runs cross the counter wrap on both the source and destination sides, and test the 0 = 256 encoding. A design that rewinds one unit early, or rewinds the wrong side, shows up in the recorded addresses and in the byte stream.

Block runs check that only the area side rewinds. Chain runs check that a conditional chain is skipped until the counter reaches zero, and that only one `done` is raised while a request arriving during the activation is ignored.

// File: rtl/dtc_pkg.sv
// Shared types for the descriptor-driven transfer engine.
// Assumes a 32-bit control word whose low 11 bits carry the fields below.
package dtc_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_REPEAT = 2'd1,
        MODE_BLOCK  = 2'd2,
        MODE_RSVD   = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ADR_FIXED = 2'd0,
        ADR_INC   = 2'd1,
        ADR_DEC   = 2'd2,
        ADR_RSVD  = 2'd3
    } addr_ctl_e;

    typedef struct packed {
        logic [20:0] spare;
        logic        chain_on_zero;
        logic        chain_en;
        logic        area_dst;
        addr_ctl_e   dst_ctl;
        addr_ctl_e   src_ctl;
        xfer_size_e  size;
        xfer_mode_e  mode;
    } ctrl_word_t;

    // Byte step of one unit of the given size.
    function automatic logic [2:0] size_step(input xfer_size_e s);
        case (s)
            SZ_BYTE: size_step = 3'd1;
            SZ_WORD: size_step = 3'd2;
            default: size_step = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dtc_addr_unit.sv
// Next-address calculator for one side (source or destination).
// Adds the signed unit step; when wrap is set, it also removes the
// span of a whole area (units * step) so the address returns to its start.
// Assumes span_units is in 1..2**RPT_W and step is 1, 2 or 4.
module dtc_addr_unit
    import dtc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int RPT_W = 8
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr_cur,
    input  addr_ctl_e       ctl,
    input  logic [2:0]      step,
    input  logic            wrap,
    input  logic [RPT_W:0]  span_units,
    output logic [AW-1:0]   addr_next
);

    logic [AW-1:0] delta;
    logic [AW-1:0] span;

    // Signed step, whole-area span and the resulting address.
    always_comb begin
        case (ctl)
            ADR_INC: delta = AW'(step);
            ADR_DEC: delta = -AW'(step);
            default: delta = '0;
        endcase
        span      = delta * AW'(span_units);
        addr_next = addr_cur + delta - (wrap ? span : '0);
    end

    // A fixed side never moves, even on an area wrap.
    assert_fixed_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == ADR_FIXED) |-> (addr_next == addr_cur));

    // An increment without wrap advances by exactly one unit.
    assert_inc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == ADR_INC && !wrap) |-> ((addr_next - addr_cur) == AW'(step)));

endmodule

// File: rtl/dtc_count_unit.sv
// Counter update for one record after its transfer.
// In repeat mode it works the 8-bit counter with reload; otherwise it
// decrements the 16-bit count. It reports whether the governing counter
// has just reached zero, and whether the repeat area must rewind.
module dtc_count_unit
    import dtc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RPT_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  xfer_mode_e        mode,
    input  logic [CNT_W-1:0]  cnt_main,
    input  logic [RPT_W-1:0]  cnt_rpt,
    input  logic [RPT_W-1:0]  reload,
    output logic [CNT_W-1:0]  cnt_main_n,
    output logic [RPT_W-1:0]  cnt_rpt_n,
    output logic              hit_zero,
    output logic              rpt_last
);

    // Select which counter moves and whether it ran out.
    always_comb begin
        rpt_last = (cnt_rpt == RPT_W'(1));
        if (mode == MODE_REPEAT) begin
            cnt_main_n = cnt_main;
            cnt_rpt_n  = rpt_last ? reload : cnt_rpt - RPT_W'(1);
            hit_zero   = rpt_last;
        end else begin
            cnt_main_n = cnt_main - CNT_W'(1);
            cnt_rpt_n  = cnt_rpt;
            hit_zero   = (cnt_main == CNT_W'(1));
        end
    end

    // Outside repeat mode the 8-bit counter is left alone.
    assert_rpt_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_REPEAT) |-> (cnt_rpt_n == cnt_rpt));

    // In repeat mode the 16-bit count is left alone.
    assert_main_untouched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_REPEAT) |-> (cnt_main_n == cnt_main));

endmodule

// File: rtl/dtc_engine.sv
// Descriptor-driven transfer engine (top).
// Fetches a four-word record from memory, moves one unit (or one block),
// writes the record back and optionally chains to the following record.
// Assumes a memory that accepts every request and returns read data one
// cycle after the request; addresses of the data are unit-aligned.
module dtc_engine
    import dtc_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          VEC_W     = 4,
    parameter int          CNT_W     = 16,
    parameter int          RPT_W     = 8,
    parameter logic [31:0] DESC_BASE = 32'h0
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_req,
    input  logic [VEC_W-1:0] act_vec,
    output logic             busy,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [1:0]       mem_size,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata
);

    localparam int REC_SHIFT = 4;
    localparam int REC_BYTES = 1 << REC_SHIFT;
    localparam logic [RPT_W:0] FULL_AREA = {1'b1, {RPT_W{1'b0}}};

    typedef enum logic [2:0] {
        S_IDLE, S_FREQ, S_FCAP, S_RREQ, S_RCAP, S_WR, S_WB, S_DONE
    } eng_state_e;

    eng_state_e        state;
    logic [AW-1:0]     rec_ptr;
    logic [1:0]        word_idx;
    ctrl_word_t        ctrl;
    logic [AW-1:0]     src_addr, dst_addr;
    logic [CNT_W-1:0]  cnt_main;
    logic [RPT_W-1:0]  cnt_rpt, reload;
    logic [RPT_W:0]    units_left;
    logic [31:0]       xdata;
    logic              chain_go;

    logic [AW-1:0]     src_next, dst_next;
    logic [CNT_W-1:0]  cnt_main_n;
    logic [RPT_W-1:0]  cnt_rpt_n;
    logic              hit_zero, rpt_last, last_unit;
    logic              area_wrap, src_wrap, dst_wrap;
    logic [RPT_W:0]    area_units, rd_units;
    logic [2:0]        step;
    logic [31:0]       rd_masked;

    // Area length, rewind conditions and size-masked read data.
    always_comb begin
        step       = size_step(ctrl.size);
        area_units = (reload == '0) ? FULL_AREA : {1'b0, reload};
        rd_units   = (mem_rdata[2*RPT_W-1:RPT_W] == '0) ? FULL_AREA
                                                        : {1'b0, mem_rdata[2*RPT_W-1:RPT_W]};
        last_unit  = (units_left == (RPT_W+1)'(1));
        area_wrap  = ((ctrl.mode == MODE_BLOCK) && last_unit) ||
                     ((ctrl.mode == MODE_REPEAT) && rpt_last);
        src_wrap   = area_wrap && !ctrl.area_dst;
        dst_wrap   = area_wrap &&  ctrl.area_dst;
        case (ctrl.size)
            SZ_BYTE: rd_masked = {24'h0, mem_rdata[7:0]};
            SZ_WORD: rd_masked = {16'h0, mem_rdata[15:0]};
            default: rd_masked = mem_rdata;
        endcase
    end

    dtc_addr_unit #(.AW(AW), .RPT_W(RPT_W)) u_src_addr (
        .clk(clk), .rst_n(rst_n), .addr_cur(src_addr), .ctl(ctrl.src_ctl),
        .step(step), .wrap(src_wrap), .span_units(area_units), .addr_next(src_next)
    );

    dtc_addr_unit #(.AW(AW), .RPT_W(RPT_W)) u_dst_addr (
        .clk(clk), .rst_n(rst_n), .addr_cur(dst_addr), .ctl(ctrl.dst_ctl),
        .step(step), .wrap(dst_wrap), .span_units(area_units), .addr_next(dst_next)
    );

    dtc_count_unit #(.CNT_W(CNT_W), .RPT_W(RPT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .mode(ctrl.mode), .cnt_main(cnt_main),
        .cnt_rpt(cnt_rpt), .reload(reload), .cnt_main_n(cnt_main_n),
        .cnt_rpt_n(cnt_rpt_n), .hit_zero(hit_zero), .rpt_last(rpt_last)
    );

    // Sequencer: fetch, read/write units, write back, chain or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            rec_ptr    <= '0;
            word_idx   <= '0;
            ctrl       <= '0;
            src_addr   <= '0;
            dst_addr   <= '0;
            cnt_main   <= '0;
            cnt_rpt    <= '0;
            reload     <= '0;
            units_left <= '0;
            xdata      <= '0;
            chain_go   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (act_req) begin
                    rec_ptr  <= AW'(DESC_BASE) + (AW'(act_vec) << REC_SHIFT);
                    word_idx <= '0;
                    state    <= S_FREQ;
                end
                S_FREQ: state <= S_FCAP;
                S_FCAP: begin
                    case (word_idx)
                        2'd0: ctrl     <= ctrl_word_t'(mem_rdata);
                        2'd1: src_addr <= AW'(mem_rdata);
                        2'd2: dst_addr <= AW'(mem_rdata);
                        default: begin
                            cnt_rpt    <= mem_rdata[RPT_W-1:0];
                            reload     <= mem_rdata[2*RPT_W-1:RPT_W];
                            cnt_main   <= mem_rdata[2*RPT_W+CNT_W-1:2*RPT_W];
                            units_left <= (ctrl.mode == MODE_BLOCK) ? rd_units
                                                                    : (RPT_W+1)'(1);
                        end
                    endcase
                    word_idx <= word_idx + 2'd1;
                    state    <= (word_idx == 2'd3) ? S_RREQ : S_FREQ;
                end
                S_RREQ: state <= S_RCAP;
                S_RCAP: begin
                    xdata <= rd_masked;
                    state <= S_WR;
                end
                S_WR: begin
                    src_addr   <= src_next;
                    dst_addr   <= dst_next;
                    units_left <= units_left - (RPT_W+1)'(1);
                    if (last_unit) begin
                        cnt_main <= cnt_main_n;
                        cnt_rpt  <= cnt_rpt_n;
                        chain_go <= ctrl.chain_en && (!ctrl.chain_on_zero || hit_zero);
                        word_idx <= '0;
                        state    <= S_WB;
                    end else begin
                        state <= S_RREQ;
                    end
                end
                S_WB: begin
                    word_idx <= word_idx + 2'd1;
                    if (word_idx == 2'd3) begin
                        if (chain_go) begin
                            rec_ptr <= rec_ptr + AW'(REC_BYTES);
                            state   <= S_FREQ;
                        end else begin
                            state <= S_DONE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory port and handshake outputs decoded from the state.
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_size  = SZ_LONG;
        mem_addr  = rec_ptr + AW'({word_idx, 2'b00});
        mem_wdata = '0;
        case (state)
            S_FREQ: mem_req = 1'b1;
            S_RREQ: begin
                mem_req  = 1'b1;
                mem_size = ctrl.size;
                mem_addr = src_addr;
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_size  = ctrl.size;
                mem_addr  = dst_addr;
                mem_wdata = xdata;
            end
            S_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                case (word_idx)
                    2'd0:    mem_wdata = ctrl;
                    2'd1:    mem_wdata = 32'(src_addr);
                    2'd2:    mem_wdata = 32'(dst_addr);
                    default: mem_wdata = {cnt_main, reload, cnt_rpt};
                endcase
            end
            default: ;
        endcase
    end

    // An accepted request raises busy on the next cycle.
    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && act_req) |=> busy);

    // The end-of-activation flag lasts exactly one cycle.
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // An activation ends only right after a longword record write.
    assert_done_after_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_req && mem_we && mem_size == SZ_LONG));

    // An idle engine leaves the memory port quiet.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // A unit write always has a unit left to account for it.
    assert_unit_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR) |-> (units_left != '0));

endmodule

// File: tb/dtc_engine_bench.sv
// Self-checking bench: sweeps normal-mode sizes and address controls,
// then repeat, block and chain scenarios against arithmetic expectations.
module dtc_engine_bench;

    localparam int AW    = 32;
    localparam int VEC_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             act_req = 1'b0;
    logic [VEC_W-1:0] act_vec = '0;
    logic             busy, done, mem_req, mem_we;
    logic [1:0]       mem_size;
    logic [AW-1:0]    mem_addr;
    logic [31:0]      mem_wdata;
    logic [31:0]      mem_rdata = '0;
    logic [7:0]       mem [0:1023];
    int               errors = 0;
    int               checks = 0;
    int               cycles = 0;

    always #10 clk = ~clk;

    dtc_engine #(.AW(AW), .VEC_W(VEC_W)) u_dtc_engine (
        .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_vec(act_vec),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] rd32(input logic [31:0] a);
        rd32 = {mem[10'(a + 32'd3)], mem[10'(a + 32'd2)], mem[10'(a + 32'd1)], mem[10'(a)]};
    endfunction

    // Memory model: read data one cycle after request, sized writes.
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= rd32(mem_addr);
        if (mem_req && mem_we) begin
            mem[10'(mem_addr)] <= mem_wdata[7:0];
            if (mem_size != 2'd0) mem[10'(mem_addr + 32'd1)] <= mem_wdata[15:8];
            if (mem_size >= 2'd2) begin
                mem[10'(mem_addr + 32'd2)] <= mem_wdata[23:16];
                mem[10'(mem_addr + 32'd3)] <= mem_wdata[31:24];
            end
        end
    end

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr32(input logic [31:0] a, input logic [31:0] v);
        mem[10'(a)]            = v[7:0];
        mem[10'(a + 32'd1)]    = v[15:8];
        mem[10'(a + 32'd2)]    = v[23:16];
        mem[10'(a + 32'd3)]    = v[31:24];
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkctl(input int mode, input int sz, input int sc,
                                          input int dc, input int area, input int ce,
                                          input int cz);
        mkctl = 32'(mode) | (32'(sz) << 2) | (32'(sc) << 4) | (32'(dc) << 6) |
                (32'(area) << 8) | (32'(ce) << 9) | (32'(cz) << 10);
    endfunction

    function automatic logic [31:0] dlt(input int ctl, input int sz);
        logic [31:0] st;
        st = (sz == 0) ? 32'd1 : (sz == 1) ? 32'd2 : 32'd4;
        dlt = (ctl == 1) ? st : (ctl == 2) ? -st : 32'd0;
    endfunction

    task automatic set_rec(input int v, input logic [31:0] w0, input logic [31:0] w1,
                           input logic [31:0] w2, input logic [31:0] w3);
        wr32(32'(v * 16),      w0);
        wr32(32'(v * 16 + 4),  w1);
        wr32(32'(v * 16 + 8),  w2);
        wr32(32'(v * 16 + 12), w3);
    endtask

    function automatic logic [31:0] rec(input int v, input int k);
        rec = rd32(32'(v * 16 + k * 4));
    endfunction

    // One activation; optionally pokes a second request while busy (R1).
    task automatic run(input int v, input bit poke, input string tag);
        int dn;
        int cyc;
        dn = 0;
        cyc = 0;
        @(negedge clk);
        act_req = 1'b1;
        act_vec = VEC_W'(v);
        @(negedge clk);
        act_req = 1'b0;
        check({tag, " R1 busy after accept"}, 32'(busy), 32'd1);
        if (poke) begin
            act_req = 1'b1;
            act_vec = VEC_W'(6);
        end
        while (dn == 0 && cyc < 5000) begin
            @(negedge clk);
            act_req = 1'b0;
            cyc = cyc + 1;
            if (done) dn = dn + 1;
        end
        check({tag, " R1 done seen"}, 32'(dn), 32'd1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done) dn = dn + 1;
        end
        check({tag, " R1 single done and idle"}, {31'(dn), busy}, {31'd1, 1'b0});
    endtask

    logic [31:0] pat, msk, c0;
    int          n;
    logic [7:0]  exp_rpt [0:4];
    logic [7:0]  exp_src [0:4];
    logic [7:0]  exp_byte [0:4];

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 reset busy", 32'(busy), 32'd0);
        check("R1 reset done", 32'(done), 32'd0);
        check("R11 reset mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Normal mode: every size x source control x destination control.
        n = 0;
        for (int sz = 0; sz < 3; sz++) begin
            for (int sc = 0; sc < 3; sc++) begin
                for (int dc = 0; dc < 3; dc++) begin
                    pat = 32'hA1B2C3D4 ^ (32'(n) * 32'h01030507);
                    msk = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
                    c0  = mkctl(0, sz, sc, dc, 0, 0, 0);
                    wr32(32'h1C0, pat);
                    wr32(32'h2C0, 32'h0);
                    set_rec(1, c0, 32'h1C0, 32'h2C0, {16'(5 + n), 8'h77, 8'h99});
                    run(1, 1'b0, "normal");
                    check("R3 dest data sized", rd32(32'h2C0), pat & msk);
                    check("R4 source address", rec(1, 1), 32'h1C0 + dlt(sc, sz));
                    check("R4 dest address", rec(1, 2), 32'h2C0 + dlt(dc, sz));
                    check("R5 count decrement", rec(1, 3), {16'(4 + n), 8'h77, 8'h99});
                    check("R2 control unchanged", rec(1, 0), c0);
                    n = n + 1;
                end
            end
        end

        // Normal mode count 0 means 65536.
        set_rec(1, mkctl(0, 0, 1, 1, 0, 0, 0), 32'h1C0, 32'h2C0, 32'h0000_0000);
        run(1, 1'b0, "count0");
        check("R5 zero count wraps", rec(1, 3), 32'hFFFF_0000);

        // Repeat mode, source area, bytes, reload 3.
        wr32(32'h180, 32'h0000_3322_11 << 0);
        mem[10'h180] = 8'h11; mem[10'h181] = 8'h22; mem[10'h182] = 8'h33;
        for (int i = 0; i < 8; i++) mem[10'h280 + i] = 8'h00;
        set_rec(1, mkctl(1, 0, 1, 1, 0, 0, 0), 32'h180, 32'h280, {16'h0ABC, 8'd3, 8'd3});
        exp_rpt  = '{8'd2, 8'd1, 8'd3, 8'd2, 8'd1};
        exp_src  = '{8'h81, 8'h82, 8'h80, 8'h81, 8'h82};
        exp_byte = '{8'h11, 8'h22, 8'h33, 8'h11, 8'h22};
        for (int k = 0; k < 5; k++) begin
            run(1, 1'b0, "repeat");
            check("R6 repeat counter", 32'(rec(1, 3) & 32'hFF), 32'(exp_rpt[k]));
            check("R6 area source address", rec(1, 1), {24'h000001, exp_src[k]});
            check("R8 other side advances", rec(1, 2), 32'h281 + 32'(k));
            check("R6 moved byte", 32'(mem[10'h280 + k]), 32'(exp_byte[k]));
            check("R6 main count untouched", rec(1, 3) >> 8, 32'h0ABC03);
        end

        // Repeat mode, destination area, words, reload 2, fixed source.
        wr32(32'h1C0, 32'h0000_5A6B);
        wr32(32'h300, 32'h0);
        set_rec(1, mkctl(1, 1, 0, 1, 1, 0, 0), 32'h1C0, 32'h300, {16'h0001, 8'd2, 8'd2});
        run(1, 1'b0, "rptdst1");
        check("R8 dest area step", rec(1, 2), 32'h302);
        run(1, 1'b0, "rptdst2");
        check("R8 dest area rewinds", rec(1, 2), 32'h300);
        check("R6 reload after wrap", rec(1, 3) & 32'hFF, 32'd2);
        check("R4 fixed source held", rec(1, 1), 32'h1C0);
        check("R3 word writes", rd32(32'h300), 32'h5A6B_5A6B);

        // Repeat counter 0 means 256: steps to 255, no rewind.
        set_rec(1, mkctl(1, 0, 1, 1, 0, 0, 0), 32'h180, 32'h280, 32'h0000_0000);
        run(1, 1'b0, "rpt256");
        check("R6 zero counter steps", rec(1, 3), 32'h0000_00FF);
        check("R6 no rewind at 256", rec(1, 1), 32'h181);

        // Block mode, destination area, 4 bytes per block, 2 blocks.
        for (int i = 0; i < 8; i++) mem[10'h180 + i] = 8'(8'h40 + i);
        wr32(32'h280, 32'h0);
        set_rec(1, mkctl(2, 0, 1, 1, 1, 0, 0), 32'h180, 32'h280, {16'd2, 8'd4, 8'h5A});
        run(1, 1'b0, "block1");
        check("R7 first block data", rd32(32'h280), 32'h4342_4140);
        check("R7 dest area rewinds", rec(1, 2), 32'h280);
        check("R7 source advances", rec(1, 1), 32'h184);
        check("R7 block count", rec(1, 3), {16'd1, 8'd4, 8'h5A});
        run(1, 1'b0, "block2");
        check("R7 second block data", rd32(32'h280), 32'h4746_4544);
        check("R7 block count zero", rec(1, 3), {16'd0, 8'd4, 8'h5A});
        check("R7 source continues", rec(1, 1), 32'h188);

        // Block mode, source area, longwords, 2 per block.
        wr32(32'h2A0, 32'h0);
        wr32(32'h2A4, 32'h0);
        set_rec(1, mkctl(2, 2, 1, 1, 0, 0, 0), 32'h180, 32'h2A0, {16'd1, 8'd2, 8'd0});
        run(1, 1'b0, "blocksrc");
        check("R7 long block word0", rd32(32'h2A0), 32'h4342_4140);
        check("R7 long block word1", rd32(32'h2A4), 32'h4746_4544);
        check("R8 source area rewinds", rec(1, 1), 32'h180);
        check("R8 dest advances", rec(1, 2), 32'h2A8);

        // Unconditional chain 2 -> 3, with an ignored request to 6.
        wr32(32'h1C0, 32'h0000_BBAA);
        set_rec(2, mkctl(0, 0, 1, 1, 0, 1, 0), 32'h1C0, 32'h340, {16'd3, 16'd0});
        set_rec(3, mkctl(0, 0, 1, 1, 0, 0, 0), 32'h1C1, 32'h350, {16'd7, 16'd0});
        set_rec(6, mkctl(0, 0, 1, 1, 0, 0, 0), 32'h1C0, 32'h360, {16'h55, 16'd0});
        run(2, 1'b1, "chain");
        check("R9 first record count", rec(2, 3), {16'd2, 16'd0});
        check("R9 chained record count", rec(3, 3), {16'd6, 16'd0});
        check("R9 chained data", 32'(mem[10'h350]), 32'hBB);
        check("R1 busy request ignored", rec(6, 3), {16'h55, 16'd0});
        check("R1 busy request no data", 32'(mem[10'h360]), 32'h00);

        // Conditional chain 4 -> 5 only when count reaches zero.
        set_rec(4, mkctl(0, 0, 1, 0, 0, 1, 1), 32'h1C0, 32'h370, {16'd2, 16'd0});
        set_rec(5, mkctl(0, 0, 1, 0, 0, 0, 0), 32'h1C0, 32'h378, {16'd10, 16'd0});
        run(4, 1'b0, "czero1");
        check("R10 count not zero", rec(4, 3), {16'd1, 16'd0});
        check("R10 no chain yet", rec(5, 3), {16'd10, 16'd0});
        run(4, 1'b0, "czero2");
        check("R10 count reaches zero", rec(4, 3), {16'd0, 16'd0});
        check("R10 chain taken", rec(5, 3), {16'd9, 16'd0});

        // Conditional chain in repeat mode follows the 8-bit counter.
        set_rec(4, mkctl(1, 0, 1, 1, 0, 1, 1), 32'h180, 32'h280, {16'd0, 8'd2, 8'd1});
        set_rec(5, mkctl(0, 0, 1, 0, 0, 0, 0), 32'h1C0, 32'h378, {16'd10, 16'd0});
        run(4, 1'b0, "czrpt");
        check("R10 repeat zero chains", rec(5, 3), {16'd9, 16'd0});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule